// File: doc/BRIEF.md
# Reflected Multi-Polynomial CRC Folding Engine

This block keeps a running cyclic redundancy checksum over a stream of data beats. A beat may be 8, 16 or 32 bits wide. The engine folds all of its bits into the checksum in the clock cycle it arrives, starting with bit 0 and ending with the top bit of that width. Data is never buffered: the register holds the only state.

A pulse on `initReq` loads the all-ones seed and latches which generator the stream will use. The choices are the 32-bit Ethernet polynomial (0x04C11DB7, used reflected as 0xEDB88320), the 32-bit Castagnoli polynomial (0x1EDC6F41, reflected 0x82F63B78) and the 16-bit CCITT polynomial (0x1021, reflected 0x8408). The raw register is always visible. A second output shows the same value inverted over the active width, which is the customary final form.

Top module: `crcfold_top`

## Requirements
- R1: While `rstN` is low and after its release, `crcOut` reads 0xFFFFFFFF and the Ethernet generator is in use.
- R2: On a clock edge with `initReq` high, the register loads the seed for the `polySel` presented on that edge: 0x0000FFFF for code 2 (CCITT), 0xFFFFFFFF otherwise. `crcOut` shows the seed from the next cycle.
- R3: `polySel` is sampled only on an `initReq` edge. Changing it between init pulses has no effect on the checksum.
- R4: Each beat bit b, lowest first, is applied as: feedback = crc[0] xor b; crc = crc >> 1; if feedback, crc ^= reflected polynomial. Codes: 0 = 0xEDB88320, 1 = 0x82F63B78, 2 = 0x8408.
- R5: `beatWidth` code 0 folds `beatData[7:0]`, code 1 folds `[15:0]`, and codes 2 and 3 fold `[31:0]`. Data bits above the selected width have no effect.
- R6: A beat with `beatValid` high is absorbed in one cycle, and `crcOut` shows the result on the next cycle. Without `beatValid` or `initReq`, `crcOut` holds.
- R7: While the CCITT generator is latched, `crcOut[31:16]` reads zero.
- R8: When `initReq` and `beatValid` are high on the same edge, the init wins and the beat is dropped.
- R9: `crcFinal` equals `crcOut` xor 0xFFFFFFFF for 32-bit generators, and `crcOut` xor 0x0000FFFF for CCITT.
- R10: After seeding and folding the ASCII string "123456789", `crcFinal` reads 0xCBF43926 for Ethernet, 0xE3069283 for Castagnoli and 0x906E for CCITT.
- R11: `polySel` code 3 selects the Ethernet generator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| initReq | input | 1 | Load seed and latch generator select |
| polySel | input | 2 | Generator select: 0 Ethernet, 1 Castagnoli, 2 CCITT, 3 Ethernet |
| beatValid | input | 1 | Beat present on `beatData` |
| beatWidth | input | 2 | Beat width: 0 byte, 1 halfword, 2/3 word |
| beatData | input | 32 | Beat payload, least significant bit folded first |
| crcOut | output | 32 | Raw running checksum register |
| crcFinal | output | 32 | Checksum inverted over the active width |

## Verification
Every bit of the checksum register appears directly on `crcOut`. A wrong fold, a wrong generator, a wrong width mask or a wrong bit order therefore shows on the cycle after the beat that caused it. It stays there, because the error feeds every later fold. A wrongly latched generator changes the result of the first beat after init and no earlier, so the bench follows each init with at least one beat. A stale upper half in CCITT mode shows immediately as nonzero `crcOut[31:16]`. The bench compares both outputs with a bit-serial model on every cycle, so a divergence is reported on the cycle it first appears.

// File: rtl/crcfold_pkg.sv
package crcfold_pkg;

  localparam int CRC_W    = 32;
  localparam int NARROW_W = 16;
  localparam int DATA_W   = 32;
  localparam int CNT_W    = $clog2(DATA_W + 1);

  localparam logic [CRC_W-1:0] REFL_ETH   = 32'hEDB88320;
  localparam logic [CRC_W-1:0] REFL_CAST  = 32'h82F63B78;
  localparam logic [CRC_W-1:0] REFL_CCITT = 32'h00008408;

  localparam logic [CRC_W-1:0] SEED_WIDE   = {CRC_W{1'b1}};
  localparam logic [CRC_W-1:0] SEED_NARROW = {{(CRC_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  typedef enum logic [1:0] {
    POLY_ETH   = 2'd0,
    POLY_CAST  = 2'd1,
    POLY_CCITT = 2'd2,
    POLY_ALIAS = 2'd3
  } polySel_e;

  typedef enum logic [1:0] {
    BEAT_BYTE = 2'd0,
    BEAT_HALF = 2'd1,
    BEAT_WORD = 2'd2,
    BEAT_WIDE = 2'd3
  } beatWidth_e;

  typedef struct packed {
    logic             loadSeed;
    logic             absorb;
    logic             narrow;
    logic [CRC_W-1:0] seed;
    logic [CRC_W-1:0] polyRefl;
    logic [CNT_W-1:0] nBits;
  } ctrlStrobe_t;

endpackage

// File: rtl/crcfold_ctrl.sv
module crcfold_ctrl
  import crcfold_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        initReq,
  input  logic [1:0]  polySel,
  input  logic        beatValid,
  input  logic [1:0]  beatWidth,
  output ctrlStrobe_t strb
);

  polySel_e modeQ;
  polySel_e modeNext;

  // code 3 aliases the Ethernet generator
  always_comb begin
    modeNext = polySel_e'(polySel);
    if (modeNext == POLY_ALIAS) modeNext = POLY_ETH;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        modeQ <= POLY_ETH;
    else if (initReq) modeQ <= modeNext;
  end

  always_comb begin
    strb.loadSeed = initReq;
    strb.absorb   = beatValid && !initReq;
    strb.narrow   = (modeQ == POLY_CCITT);
    strb.seed     = (modeNext == POLY_CCITT) ? SEED_NARROW : SEED_WIDE;

    unique case (modeQ)
      POLY_CAST:  strb.polyRefl = REFL_CAST;
      POLY_CCITT: strb.polyRefl = REFL_CCITT;
      default:    strb.polyRefl = REFL_ETH;
    endcase

    unique case (beatWidth_e'(beatWidth))
      BEAT_BYTE: strb.nBits = CNT_W'(8);
      BEAT_HALF: strb.nBits = CNT_W'(16);
      default:   strb.nBits = CNT_W'(DATA_W);
    endcase
  end

endmodule

// File: rtl/crcfold_path.sv
module crcfold_path
  import crcfold_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [DATA_W-1:0] beatData,
  output logic [CRC_W-1:0]  crcOut,
  output logic [CRC_W-1:0]  crcFinal
);

  logic [CRC_W-1:0]             crcQ;
  logic [DATA_W:0][CRC_W-1:0]   chain;

  assign chain[0] = crcQ;

  // one unrolled reflected shift step per data bit, lowest bit first
  for (genvar i = 0; i < DATA_W; i++) begin : g_step
    logic             feedBack;
    logic [CRC_W-1:0] shifted;
    logic [CRC_W-1:0] stepped;
    always_comb begin
      feedBack = chain[i][0] ^ beatData[i];
      shifted  = chain[i] >> 1;
      stepped  = feedBack ? (shifted ^ strb.polyRefl) : shifted;
      chain[i+1] = (strb.nBits > CNT_W'(i)) ? stepped : chain[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              crcQ <= SEED_WIDE;
    else if (strb.loadSeed) crcQ <= strb.seed;
    else if (strb.absorb)   crcQ <= chain[DATA_W];
  end

  assign crcOut   = crcQ;
  assign crcFinal = crcQ ^ (strb.narrow ? SEED_NARROW : SEED_WIDE);

endmodule

// File: rtl/crcfold_top.sv
module crcfold_top
  import crcfold_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              initReq,
  input  logic [1:0]        polySel,
  input  logic              beatValid,
  input  logic [1:0]        beatWidth,
  input  logic [DATA_W-1:0] beatData,
  output logic [CRC_W-1:0]  crcOut,
  output logic [CRC_W-1:0]  crcFinal
);

  ctrlStrobe_t strb;

  crcfold_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .initReq   (initReq),
    .polySel   (polySel),
    .beatValid (beatValid),
    .beatWidth (beatWidth),
    .strb      (strb)
  );

  crcfold_path path_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .beatData (beatData),
    .crcOut   (crcOut),
    .crcFinal (crcFinal)
  );

endmodule

// File: rtl/crcfold_chk.sv
module crcfold_chk (
  input logic        clk,
  input logic        rstN,
  input logic        initReq,
  input logic [1:0]  polySel,
  input logic        beatValid,
  input logic [31:0] crcOut,
  input logic [31:0] crcFinal
);

  logic narrowQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        narrowQ <= 1'b0;
    else if (initReq) narrowQ <= (polySel == 2'd2);
  end

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!initReq && !beatValid) |=> $stable(crcOut));

  // R2
  seed_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    initReq |=> (crcOut == (($past(polySel) == 2'd2) ? 32'h0000FFFF : 32'hFFFFFFFF)));

  // R7
  narrow_upper_chk: assert property (@(posedge clk) disable iff (!rstN)
    narrowQ |-> (crcOut[31:16] == 16'h0000));

  // R9
  final_view_chk: assert property (@(posedge clk) disable iff (!rstN)
    crcFinal == (crcOut ^ (narrowQ ? 32'h0000FFFF : 32'hFFFFFFFF)));

endmodule

bind crcfold_top crcfold_chk chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .initReq   (initReq),
  .polySel   (polySel),
  .beatValid (beatValid),
  .crcOut    (crcOut),
  .crcFinal  (crcFinal)
);

// File: tb/crcfold_tb.sv
`timescale 1ns/1ps
module crcfold_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        initReq = 1'b0;
  logic [1:0]  polySel = 2'd0;
  logic        beatValid = 1'b0;
  logic [1:0]  beatWidth = 2'd0;
  logic [31:0] beatData = 32'h0;
  logic [31:0] crcOut;
  logic [31:0] crcFinal;

  int    checks = 0;
  int    failures = 0;
  bit    doneFlag = 1'b0;
  string curReq = "R1";

  logic [31:0] refCrc = 32'hFFFFFFFF;
  int          refMode = 0;

  always #4 clk = ~clk;

  crcfold_top dut_i (
    .clk(clk), .rstN(rstN), .initReq(initReq), .polySel(polySel),
    .beatValid(beatValid), .beatWidth(beatWidth), .beatData(beatData),
    .crcOut(crcOut), .crcFinal(crcFinal)
  );

  function automatic logic [31:0] refFold(logic [31:0] c, logic [31:0] d, int nb, int mode);
    logic [31:0] poly;
    poly = (mode == 1) ? 32'h82F63B78 : (mode == 2) ? 32'h00008408 : 32'hEDB88320;
    for (int b = 0; b < nb; b++) begin
      if (c[0] ^ d[b]) c = (c >> 1) ^ poly;
      else             c = c >> 1;
    end
    return c;
  endfunction

  function automatic logic [31:0] refMask(int mode);
    return (mode == 2) ? 32'h0000FFFF : 32'hFFFFFFFF;
  endfunction

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (!rstN) begin
      refCrc  <= 32'hFFFFFFFF;
      refMode <= 0;
    end else if (initReq) begin
      refMode <= (polySel == 2'd3) ? 0 : int'(polySel);
      refCrc  <= refMask((polySel == 2'd3) ? 0 : int'(polySel));
    end else if (beatValid) begin
      refCrc <= refFold(refCrc, beatData,
                        (beatWidth == 2'd0) ? 8 : (beatWidth == 2'd1) ? 16 : 32, refMode);
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !doneFlag) begin
      check({curReq, " raw"}, crcOut, refCrc);
      check("R9 final", crcFinal, refCrc ^ refMask(refMode));
    end
  end

  task automatic doInit(int sel);
    initReq = 1'b1; polySel = 2'(sel);
    @(negedge clk);
    initReq = 1'b0;
  endtask

  task automatic doBeat(int w, logic [31:0] d);
    beatValid = 1'b1; beatWidth = 2'(w); beatData = d;
    @(negedge clk);
    beatValid = 1'b0; beatData = 32'hDEADBEEF;
  endtask

  task automatic feedBytes(logic [31:0] junk);
    string s = "123456789";
    for (int k = 0; k < 9; k++) doBeat(0, {junk[31:8], s[k]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!doneFlag) begin
      doneFlag = 1'b1;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    logic [31:0] exp [3];
    exp[0] = 32'hCBF43926; exp[1] = 32'hE3069283; exp[2] = 32'h0000906E;

    repeat (3) @(negedge clk);
    curReq = "R1";
    check("R1 reset value", crcOut, 32'hFFFFFFFF);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", crcOut, 32'hFFFFFFFF);

    for (int m = 0; m < 3; m++) begin
      curReq = "R2";
      doInit(m);
      check("R2 seed", crcOut, refMask(m));
      curReq = "R10";
      feedBytes(32'h0);
      check("R10 check value bytes", crcFinal, exp[m]);
      if (m == 2) check("R7 upper zero", {16'h0, crcOut[31:16]}, 32'h0);

      curReq = "R5";
      doInit(m);
      feedBytes(32'hABCDEF00);
      check("R5 byte upper ignored", crcFinal, exp[m]);
      doInit(m);
      doBeat(1, 32'h77773231); doBeat(1, 32'h55553433);
      doBeat(1, 32'h00003635); doBeat(1, 32'hFFFF3837);
      doBeat(0, 32'h12345639);
      check("R5 halfword beats", crcFinal, exp[m]);
      doInit(m);
      doBeat(2, 32'h34333231); doBeat(3, 32'h38373635); doBeat(0, 32'h00000039);
      check("R4 word beats", crcFinal, exp[m]);
    end

    curReq = "R11";
    doInit(3);
    feedBytes(32'h0);
    check("R11 alias Ethernet", crcFinal, exp[0]);

    curReq = "R3";
    doInit(1);
    polySel = 2'd2;
    feedBytes(32'h0);
    check("R3 select ignored mid-stream", crcFinal, exp[1]);

    curReq = "R8";
    doBeat(0, 32'h11);
    initReq = 1'b1; polySel = 2'd0; beatValid = 1'b1; beatData = 32'hCAFEF00D; beatWidth = 2'd2;
    @(negedge clk);
    initReq = 1'b0; beatValid = 1'b0;
    check("R8 init beats beat", crcOut, 32'hFFFFFFFF);
    initReq = 1'b1; polySel = 2'd2; beatValid = 1'b1;
    @(negedge clk);
    initReq = 1'b0; beatValid = 1'b0;
    check("R8 init beats beat narrow", crcOut, 32'h0000FFFF);

    curReq = "R6";
    doBeat(2, 32'h0BADC0DE);
    held = crcOut;
    for (int k = 0; k < 3; k++) begin
      beatData = 32'h13572468 + 32'(k);
      @(negedge clk);
    end
    check("R6 idle hold", crcOut, held);

    curReq = "R4";
    for (int n = 0; n < 400; n++) begin
      if (n % 50 == 0) doInit($urandom_range(0, 3));
      if ($urandom_range(0, 3) == 0) @(negedge clk);
      else doBeat($urandom_range(0, 3), $urandom());
    end

    doneFlag = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule